// File: doc/BRIEF.md
# Capability Page Entry Access Checker

This block sits next to the load/store path of a 64-bit paged memory unit. For every translated access it looks at two bits of the page entry: a capability-write permission bit (called CW below) and a per-page generation bit (called CRG below). From these bits it decides whether a capability load returns its tag cleared, whether the access raises a page fault, and whether the page entry must be upgraded in hardware. The inputs are the access kind, the effective privilege of the access, the virtualization flag, the tag read from memory and the tag being stored. Two configuration inputs choose the fault scheme and choose between software and hardware accessed/dirty handling.

The block holds the user-revocation generation bit (UCRG) of the supervisor status word and of the virtual supervisor status word. The machine status view shares the supervisor bit. In the status word the bit sits at position 61. The active generation is the virtual supervisor copy when the virtualization flag is set, and the supervisor copy otherwise. A page upgrade is presented to the page-table walker as a compare-and-swap request. The request is held until the walker reports a successful swap. A failed swap leaves the request up for a retry and raises no fault.

The decision outputs are combinational from the current access. The status bits and the upgrade request are registered.

Top module: `cap_pte_guard`

## Requirements
- R1: After reset both status read words are zero and `upd_req` is low.
- R2: A capability load (`acc_kind`=1) or capability AMO (`acc_kind`=3) to a page with CW=0 asserts `tag_clear` in both user and supervisor mode, and raises no load-type fault (`page_fault` with `fault_store`=0).
- R3: In user mode (`acc_user`=1) with CW=1, a capability load or AMO whose page CRG differs from the active generation raises `page_fault` with `fault_store`=0, provided `cfg_tagged_only`=0.
- R4: With `cfg_tagged_only`=1, the fault of R3 is raised only when `ld_tag`=1. Otherwise the access completes normally.
- R5: A capability load or AMO with CW=1 completes with no fault and no tag clear in supervisor mode (`acc_user`=0) for any CRG value, and in user mode when CRG equals the active generation.
- R6: A capability store (`acc_kind`=2) or AMO with `st_tag`=1 to a page with CW=0 raises `page_fault` with `fault_store`=1 when `cfg_hw_ad`=0.
- R7: When `cfg_hw_ad`=1, the store of R6 raises no fault. From the next cycle `upd_req` is high, with `upd_new_crg` equal to the active generation at the time of the store and `upd_old_crg` equal to the page CRG as it was. The request stays high with stable fields until a cycle with `cas_done`=1 and `cas_ok`=1. After that cycle it drops.
- R8: A cycle with `cas_done`=1 and `cas_ok`=0 keeps the request pending (a retry) and raises no fault.
- R9: An upgrade that arrives while a request is already pending is not captured: the pending fields are unchanged.
- R10: The active generation is the virtual supervisor bit when `acc_virt`=1 and the supervisor bit otherwise. A write through `stat_wr_s` or `stat_wr_m` loads bit 61 of `stat_wdata` into the supervisor bit. A write through `stat_wr_vs` loads that bit into the virtual supervisor bit. Each write takes effect from the next cycle.
- R11: Status read words carry the generation bit at bit 61 and zero in every other bit.
- R12: Plain accesses (`acc_kind`=0), and capability stores with `st_tag`=0 to any page, raise no fault, clear no tag and start no upgrade.
- R13: With `REVOKE_EN`=0, both status words read zero, writes are ignored and the page CRG is treated as zero, so user-mode generation faults never occur. The CW checks of R2 and R6 still apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_kind | input | 2 | 0 plain, 1 capability load, 2 capability store, 3 capability AMO |
| acc_user | input | 1 | Effective privilege of the access is user (1) or supervisor (0) |
| acc_virt | input | 1 | Virtualization flag of the access |
| pte_cw | input | 1 | Page capability-write bit |
| pte_crg | input | 1 | Page generation bit |
| ld_tag | input | 1 | Tag of the capability read from memory |
| st_tag | input | 1 | Tag of the capability being written |
| cfg_tagged_only | input | 1 | Generation fault only for tagged loaded capabilities |
| cfg_hw_ad | input | 1 | Hardware accessed/dirty updating in effect |
| stat_wr_s | input | 1 | Write strobe, supervisor status view |
| stat_wr_vs | input | 1 | Write strobe, virtual supervisor status view |
| stat_wr_m | input | 1 | Write strobe, machine status view (aliases supervisor bit) |
| stat_wdata | input | STAT_W | Status write word |
| cas_done | input | 1 | Walker finished a compare-and-swap attempt |
| cas_ok | input | 1 | The attempt succeeded |
| stat_s_rdata | output | STAT_W | Supervisor/machine status read view |
| stat_vs_rdata | output | STAT_W | Virtual supervisor status read view |
| tag_clear | output | 1 | Clear the tag of the loaded capability |
| page_fault | output | 1 | Raise a page fault |
| fault_store | output | 1 | Fault is store type (1) or load type (0) |
| upd_req | output | 1 | Compare-and-swap upgrade request pending |
| upd_old_crg | output | 1 | Expected old CRG (CW expected 0) |
| upd_new_crg | output | 1 | CRG to write (CW written 1) |

## Verification
The checker watches, on every cycle, that a capability load to a CW=0 page clears the tag without a load fault, and that supervisor accesses to CW=1 pages never fault. It also checks that plain accesses stay silent, that a store fault only appears under software accessed/dirty handling, and that a pending upgrade holds stable until a successful swap and then drops. Whether a fault matches the correct generation copy after status writes, the tagged-only scheme, and the capture of the generation into the upgrade can only be shown by the bench. The bench compares the design against a reference model under random traffic, and checks a second instance built without revocation.

// File: rtl/cpg_pkg.sv
// Shared types for the capability page entry checker.
package cpg_pkg;
    typedef enum logic [1:0] {
        ACC_PLAIN  = 2'd0,
        ACC_CLOAD  = 2'd1,
        ACC_CSTORE = 2'd2,
        ACC_CAMO   = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic tag_clear;
        logic page_fault;
        logic fault_store;
        logic upgrade;
    } verdict_t;
endpackage

// File: rtl/cpg_status_regs.sv
// Holds the user generation bits of the supervisor and virtual supervisor
// status words; the machine view writes the supervisor bit. Assumes at most
// one software write per view per cycle. With REVOKE_EN=0 the bits are zero.
module cpg_status_regs #(
    parameter int STAT_W    = 64,
    parameter int UCRG_BIT  = 61,
    parameter bit REVOKE_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_s,
    input  logic              wr_vs,
    input  logic              wr_m,
    input  logic              wbit,
    input  logic              virt,
    output logic              ucrg_act,
    output logic [STAT_W-1:0] s_rdata,
    output logic [STAT_W-1:0] vs_rdata
);
    localparam logic [STAT_W-1:0] ONE_W = STAT_W'(1);

    logic ucrg_s;
    logic ucrg_vs;

    generate
        if (REVOKE_EN) begin : g_rev
            // Generation bit storage, updated by status writes.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ucrg_s  <= 1'b0;
                    ucrg_vs <= 1'b0;
                end else begin
                    if (wr_s || wr_m) ucrg_s  <= wbit;
                    if (wr_vs)        ucrg_vs <= wbit;
                end
            end
        end else begin : g_norev
            assign ucrg_s  = 1'b0;
            assign ucrg_vs = 1'b0;
        end
    endgenerate

    // Active generation follows the virtualization flag.
    assign ucrg_act = virt ? ucrg_vs : ucrg_s;

    // Read views place the bit at its word position.
    assign s_rdata  = ucrg_s  ? (ONE_W << UCRG_BIT) : '0;
    assign vs_rdata = ucrg_vs ? (ONE_W << UCRG_BIT) : '0;
endmodule

// File: rtl/cpg_decide.sv
// Combinational verdict for one access: tag clear, fault and fault type,
// and whether an entry upgrade is needed. Assumes the privilege input is the
// effective mode of the access. With REVOKE_EN=0 the page CRG reads as zero.
module cpg_decide
    import cpg_pkg::*;
#(
    parameter bit REVOKE_EN = 1'b1
) (
    input  logic      valid,
    input  acc_kind_e kind,
    input  logic      user,
    input  logic      cw,
    input  logic      crg,
    input  logic      ld_tag,
    input  logic      st_tag,
    input  logic      tagged_only,
    input  logic      hw_ad,
    input  logic      ucrg_act,
    output logic      crg_eff,
    output verdict_t  verdict
);
    logic is_load;
    logic is_store;
    logic gen_miss;
    logic load_fault;
    logic store_need;

    assign crg_eff = REVOKE_EN ? crg : 1'b0;

    // Load side and store side classification and checks.
    always_comb begin
        is_load    = (kind == ACC_CLOAD)  || (kind == ACC_CAMO);
        is_store   = (kind == ACC_CSTORE) || (kind == ACC_CAMO);
        gen_miss   = crg_eff != ucrg_act;
        load_fault = valid && is_load && cw && user && gen_miss
                     && (!tagged_only || ld_tag);
        store_need = valid && is_store && st_tag && !cw;

        verdict.tag_clear   = valid && is_load && !cw;
        verdict.fault_store = store_need && !hw_ad;
        verdict.page_fault  = load_fault || verdict.fault_store;
        verdict.upgrade     = store_need && hw_ad;
    end
endmodule

// File: rtl/cpg_upgrade_ctl.sv
// Holds one compare-and-swap upgrade request to the walker. Captures the
// active generation and the old CRG when idle; a failed swap keeps the
// request for retry. New upgrades are not captured while one is pending.
module cpg_upgrade_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic upgrade,
    input  logic ucrg_act,
    input  logic crg_old,
    input  logic cas_done,
    input  logic cas_ok,
    output logic pending,
    output logic old_crg,
    output logic new_crg
);
    // Request state: capture when idle, release on successful swap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            old_crg <= 1'b0;
            new_crg <= 1'b0;
        end else if (!pending) begin
            if (upgrade) begin
                pending <= 1'b1;
                old_crg <= crg_old;
                new_crg <= ucrg_act;
            end
        end else if (cas_done && cas_ok) begin
            pending <= 1'b0;
        end
    end
endmodule

// File: rtl/cap_pte_guard.sv
// Top of the capability page entry checker: joins the status bit holder,
// the per-access verdict and the upgrade request holder. Assumes accesses
// arrive already translated with their page entry bits.
module cap_pte_guard
    import cpg_pkg::*;
#(
    parameter int STAT_W    = 64,
    parameter int UCRG_BIT  = 61,
    parameter bit REVOKE_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [1:0]        acc_kind,
    input  logic              acc_user,
    input  logic              acc_virt,
    input  logic              pte_cw,
    input  logic              pte_crg,
    input  logic              ld_tag,
    input  logic              st_tag,
    input  logic              cfg_tagged_only,
    input  logic              cfg_hw_ad,
    input  logic              stat_wr_s,
    input  logic              stat_wr_vs,
    input  logic              stat_wr_m,
    input  logic [STAT_W-1:0] stat_wdata,
    input  logic              cas_done,
    input  logic              cas_ok,
    output logic [STAT_W-1:0] stat_s_rdata,
    output logic [STAT_W-1:0] stat_vs_rdata,
    output logic              tag_clear,
    output logic              page_fault,
    output logic              fault_store,
    output logic              upd_req,
    output logic              upd_old_crg,
    output logic              upd_new_crg
);
    logic     ucrg_act;
    logic     crg_eff;
    verdict_t verdict;

    cpg_status_regs #(
        .STAT_W(STAT_W), .UCRG_BIT(UCRG_BIT), .REVOKE_EN(REVOKE_EN)
    ) u_status (
        .clk(clk), .rst_n(rst_n),
        .wr_s(stat_wr_s), .wr_vs(stat_wr_vs), .wr_m(stat_wr_m),
        .wbit(stat_wdata[UCRG_BIT]), .virt(acc_virt),
        .ucrg_act(ucrg_act), .s_rdata(stat_s_rdata), .vs_rdata(stat_vs_rdata)
    );

    cpg_decide #(.REVOKE_EN(REVOKE_EN)) u_decide (
        .valid(acc_valid), .kind(acc_kind_e'(acc_kind)), .user(acc_user),
        .cw(pte_cw), .crg(pte_crg), .ld_tag(ld_tag), .st_tag(st_tag),
        .tagged_only(cfg_tagged_only), .hw_ad(cfg_hw_ad),
        .ucrg_act(ucrg_act), .crg_eff(crg_eff), .verdict(verdict)
    );

    cpg_upgrade_ctl u_upgrade (
        .clk(clk), .rst_n(rst_n), .upgrade(verdict.upgrade),
        .ucrg_act(ucrg_act), .crg_old(crg_eff),
        .cas_done(cas_done), .cas_ok(cas_ok),
        .pending(upd_req), .old_crg(upd_old_crg), .new_crg(upd_new_crg)
    );

    assign tag_clear   = verdict.tag_clear;
    assign page_fault  = verdict.page_fault;
    assign fault_store = verdict.fault_store;
endmodule

// File: rtl/cpg_checker.sv
// Cycle-level properties of the capability page entry checker, bound to
// every instance of the top module.
module cpg_checker #(
    parameter int STAT_W   = 64,
    parameter int UCRG_BIT = 61
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic [1:0]        acc_kind,
    input logic              acc_user,
    input logic              pte_cw,
    input logic              cfg_hw_ad,
    input logic              cas_done,
    input logic              cas_ok,
    input logic [STAT_W-1:0] stat_s_rdata,
    input logic [STAT_W-1:0] stat_vs_rdata,
    input logic              tag_clear,
    input logic              page_fault,
    input logic              fault_store,
    input logic              upd_req,
    input logic              upd_old_crg,
    input logic              upd_new_crg
);
    localparam logic [STAT_W-1:0] KEEP = ~(STAT_W'(1) << UCRG_BIT);

    logic cap_ld;
    assign cap_ld = acc_valid && (acc_kind == 2'd1 || acc_kind == 2'd3);

    assert_cw0_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cap_ld && !pte_cw |-> tag_clear && !(page_fault && !fault_store));

    assert_super_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && !acc_user && pte_cw |-> !page_fault && !tag_clear);

    assert_plain_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && acc_kind == 2'd0 |-> !page_fault && !tag_clear);

    assert_store_fault_sw_R6: assert property (@(posedge clk) disable iff (!rst_n)
        page_fault && fault_store |-> !cfg_hw_ad);

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        upd_req && !(cas_done && cas_ok)
        |=> upd_req && $stable(upd_new_crg) && $stable(upd_old_crg));

    assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        upd_req && cas_done && cas_ok |=> !upd_req);

    assert_word_layout_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_s_rdata & KEEP) == '0) && ((stat_vs_rdata & KEEP) == '0));
endmodule

bind cap_pte_guard cpg_checker #(.STAT_W(STAT_W), .UCRG_BIT(UCRG_BIT)) u_chk (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_kind(acc_kind),
    .acc_user(acc_user), .pte_cw(pte_cw), .cfg_hw_ad(cfg_hw_ad),
    .cas_done(cas_done), .cas_ok(cas_ok),
    .stat_s_rdata(stat_s_rdata), .stat_vs_rdata(stat_vs_rdata),
    .tag_clear(tag_clear), .page_fault(page_fault), .fault_store(fault_store),
    .upd_req(upd_req), .upd_old_crg(upd_old_crg), .upd_new_crg(upd_new_crg)
);

// File: tb/test_cap_pte_guard.sv
module test_cap_pte_guard;
    localparam int W  = 64;
    localparam int UB = 61;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_valid = 0, acc_user = 0, acc_virt = 0, pte_cw = 0, pte_crg = 0;
    logic [1:0] acc_kind = 2'd0;
    logic ld_tag = 0, st_tag = 0, cfg_tagged_only = 0, cfg_hw_ad = 0;
    logic stat_wr_s = 0, stat_wr_vs = 0, stat_wr_m = 0;
    logic [W-1:0] stat_wdata = '0;
    logic cas_done = 0, cas_ok = 0;
    logic [W-1:0] s_rd, vs_rd, s_rd2, vs_rd2;
    logic tag_clear, page_fault, fault_store, upd_req, upd_old, upd_new;
    logic tc2, pf2, fs2, ur2, uo2, un2;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    // Reference state
    logic m_s = 0, m_vs = 0, m_pend = 0, m_old = 0, m_new = 0;

    always #4 clk = ~clk;

    cap_pte_guard i_cap_pte_guard (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_kind(acc_kind),
        .acc_user(acc_user), .acc_virt(acc_virt), .pte_cw(pte_cw), .pte_crg(pte_crg),
        .ld_tag(ld_tag), .st_tag(st_tag), .cfg_tagged_only(cfg_tagged_only),
        .cfg_hw_ad(cfg_hw_ad), .stat_wr_s(stat_wr_s), .stat_wr_vs(stat_wr_vs),
        .stat_wr_m(stat_wr_m), .stat_wdata(stat_wdata), .cas_done(cas_done),
        .cas_ok(cas_ok), .stat_s_rdata(s_rd), .stat_vs_rdata(vs_rd),
        .tag_clear(tag_clear), .page_fault(page_fault), .fault_store(fault_store),
        .upd_req(upd_req), .upd_old_crg(upd_old), .upd_new_crg(upd_new)
    );

    // Second instance without revocation; software A/D only.
    cap_pte_guard #(.REVOKE_EN(1'b0)) i_cap_pte_guard_norev (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_kind(acc_kind),
        .acc_user(acc_user), .acc_virt(acc_virt), .pte_cw(pte_cw), .pte_crg(pte_crg),
        .ld_tag(ld_tag), .st_tag(st_tag), .cfg_tagged_only(cfg_tagged_only),
        .cfg_hw_ad(1'b0), .stat_wr_s(stat_wr_s), .stat_wr_vs(stat_wr_vs),
        .stat_wr_m(stat_wr_m), .stat_wdata(stat_wdata), .cas_done(1'b0),
        .cas_ok(1'b0), .stat_s_rdata(s_rd2), .stat_vs_rdata(vs_rd2),
        .tag_clear(tc2), .page_fault(pf2), .fault_store(fs2),
        .upd_req(ur2), .upd_old_crg(uo2), .upd_new_crg(un2)
    );

    // Reference verdict {tag_clear, page_fault, fault_store, upgrade}.
    function automatic logic [3:0] ref_verdict(input logic rev, input logic hw,
                                               input logic act);
        logic ld, st, crg, lf, sn, sf;
        ld  = acc_valid && (acc_kind == 2'd1 || acc_kind == 2'd3);
        st  = acc_valid && (acc_kind == 2'd2 || acc_kind == 2'd3);
        crg = rev ? pte_crg : 1'b0;
        lf  = ld && pte_cw && acc_user && (crg != act) && (!cfg_tagged_only || ld_tag);
        sn  = st && st_tag && !pte_cw;
        sf  = sn && !hw;
        return {ld && !pte_cw, lf || sf, sf, sn && hw};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic string tag_of();
        if (!acc_valid || acc_kind == 2'd0) return "R12";
        if (acc_kind == 2'd2) return pte_cw ? "R12" : (cfg_hw_ad ? "R7" : "R6");
        if (!pte_cw) return "R2";
        if (!acc_user) return "R5";
        return cfg_tagged_only ? "R4" : "R3";
    endfunction

    // One cycle: inputs already driven after a falling edge; check, then clock.
    task automatic step();
        logic act;
        logic [3:0] v, v2;
        #2;
        act = acc_virt ? m_vs : m_s;
        v  = ref_verdict(1'b1, cfg_hw_ad, act);
        v2 = ref_verdict(1'b0, 1'b0, 1'b0);
        chk(tag_of(), "tag_clear",   W'(tag_clear),   W'(v[3]));
        chk(tag_of(), "page_fault",  W'(page_fault),  W'(v[2]));
        chk(tag_of(), "fault_store", W'(fault_store), W'(v[1]));
        chk("R10", "s view",  s_rd,  m_s  ? (W'(1) << UB) : '0);
        chk("R11", "vs view", vs_rd, m_vs ? (W'(1) << UB) : '0);
        chk("R7", "upd_req", W'(upd_req), W'(m_pend));
        if (m_pend) begin
            chk("R9", "upd_new_crg", W'(upd_new), W'(m_new));
            chk("R9", "upd_old_crg", W'(upd_old), W'(m_old));
        end
        chk("R13", "norev fault",  W'(pf2), W'(v2[2]));
        chk("R13", "norev clear",  W'(tc2), W'(v2[3]));
        chk("R13", "norev status", s_rd2 | vs_rd2, '0);
        chk("R13", "norev upd",    W'(ur2), '0);
        @(posedge clk);
        if (!m_pend) begin
            if (v[0]) begin
                m_pend = 1'b1;
                m_new  = act;
                m_old  = pte_crg;
            end
        end else if (cas_done && cas_ok) m_pend = 1'b0;
        if (stat_wr_s || stat_wr_m) m_s  = stat_wdata[UB];
        if (stat_wr_vs)             m_vs = stat_wdata[UB];
        @(negedge clk);
    endtask

    task automatic set_acc(input logic [1:0] k, input logic u, input logic vf,
                           input logic cw, input logic crg, input logic lt,
                           input logic stg, input logic to, input logic hw);
        acc_valid = 1'b1; acc_kind = k; acc_user = u; acc_virt = vf;
        pte_cw = cw; pte_crg = crg; ld_tag = lt; st_tag = stg;
        cfg_tagged_only = to; cfg_hw_ad = hw;
        stat_wr_s = 0; stat_wr_vs = 0; stat_wr_m = 0;
        cas_done = 0; cas_ok = 0;
    endtask

    task automatic write_stat(input logic s, input logic vs, input logic m,
                              input logic b);
        acc_valid = 0;
        stat_wr_s = s; stat_wr_vs = vs; stat_wr_m = m;
        stat_wdata = {W{1'b1}};
        stat_wdata[UB] = b;
        step();
        stat_wr_s = 0; stat_wr_vs = 0; stat_wr_m = 0;
    endtask

    initial begin : watchdog
        #(8 * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        int seed;
        seed = 32'h5a17;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "s view reset",  s_rd,  '0);
        chk("R1", "vs view reset", vs_rd, '0);
        chk("R1", "upd_req reset", W'(upd_req), '0);

        // R2 both modes, CW=0 load
        set_acc(2'd1, 1, 0, 0, 1, 1, 0, 0, 0); step();
        set_acc(2'd3, 0, 0, 0, 0, 1, 0, 0, 0); step();
        // R10 machine view aliases supervisor; vs separate
        write_stat(0, 0, 1, 1);
        write_stat(0, 1, 0, 0);
        // R3 user mismatch against s (1) with crg 0; R5 match on vs (0)
        set_acc(2'd1, 1, 0, 1, 0, 0, 0, 0, 0); step();
        set_acc(2'd1, 1, 1, 1, 0, 1, 0, 0, 0); step();
        // R4 tagged-only
        set_acc(2'd1, 1, 0, 1, 0, 0, 0, 1, 0); step();
        set_acc(2'd3, 1, 0, 1, 0, 1, 0, 1, 0); step();
        // R5 supervisor any CRG
        set_acc(2'd1, 0, 0, 1, 0, 1, 0, 0, 0); step();
        // R6 software A/D store fault
        set_acc(2'd2, 1, 0, 0, 0, 0, 1, 0, 0); step();
        // R12 untagged store and plain
        set_acc(2'd2, 1, 0, 0, 1, 0, 0, 0, 1); step();
        set_acc(2'd0, 1, 0, 0, 1, 1, 1, 0, 1); step();
        // R7 upgrade captures s generation (1)
        set_acc(2'd2, 0, 0, 0, 0, 0, 1, 0, 1); step();
        // R9 second upgrade (virt, gen 0) not captured; R8 failed swap retries
        set_acc(2'd3, 1, 1, 0, 1, 0, 1, 0, 1); cas_done = 1; cas_ok = 0; step();
        set_acc(2'd0, 0, 0, 0, 0, 0, 0, 0, 0); step();
        cas_done = 1; cas_ok = 1; step();
        cas_done = 0; cas_ok = 0; step();

        // Random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r;
            r = $urandom;
            set_acc(r[1:0], r[2], r[3], r[4], r[5], r[6], r[7], r[8], r[9]);
            acc_valid = r[10] | r[11];
            if (r[14:12] == 3'd0) begin
                stat_wr_s = r[15]; stat_wr_vs = r[16]; stat_wr_m = r[17];
                stat_wdata = {$urandom, $urandom};
            end
            if (m_pend) begin
                cas_done = r[18]; cas_ok = r[19];
            end
            step();
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule